// File: doc/BRIEF.md
# Delay-Line TDC Bin-to-Picosecond Calibrator

This block sits behind a tapped-delay-line time-to-digital converter and turns each raw fine-time bin code into a time in picoseconds. Every accepted hit adds one to a per-bin counter. The counters therefore build a code-density histogram. Once a fixed batch of hits has been gathered, a sequencer walks the bins in ascending order. It keeps a running sum of the counts and writes one scaled value per bin into a bin-to-time table. The written value is the centre of the bin, expressed as a fraction of the clock period. The sequencer clears each counter as it reads it, and the next batch starts.

The table has two banks. Lookups are served from the active bank while the sequencer fills the other bank. The banks swap in a single clock edge when the walk ends. Bins in a real delay chain differ in width, and some are far wider than the rest. Their widths also move with supply voltage and temperature. Because the table is rebuilt from fresh statistics for every batch, it tracks those changes with no outside help. Before the first rebuild finishes, both banks hold a uniform ramp of code times a nominal bin width.

Top module: `tdc_bin_calibrator`

## Requirements
- R1: While `hit_valid` is low, `cal_valid` is low one cycle later. After reset `cal_valid` is low.
- R2: A hit presented in cycle t produces `cal_valid` high in cycle t+1, with `cal_ps` carrying its converted time.
- R3: Until the first rebuild completes, a hit with code c returns c × NOM_PS.
- R4: Each hit that arrives outside a rebuild adds one to the counter of its code. The hit that completes a batch of BATCH such hits starts a rebuild on the next edge.
- R5: After a rebuild, the entry for code c equals floor((2·S + n) × CLK_PS / (2·BATCH)), truncated to TIME_W bits. Here n is the count of code c in the batch, and S is the sum of the counts of all codes below c.
- R6: A rebuild takes exactly NBINS cycles, visiting codes 0 to NBINS−1 in order. Hits in those cycles are converted with the old table and are not counted.
- R7: The new table takes effect for hits from the first cycle after the rebuild's last cycle. The bank switch happens in one edge, so no hit ever sees a mix of the two tables.
- R8: Every counter is zero after a rebuild, so each table depends only on the hits of its own batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_valid | input | 1 | A hit is present this cycle |
| hit_code | input | BIN_W | Raw fine-time bin code of the hit |
| cal_valid | output | 1 | Converted time is present |
| cal_ps | output | TIME_W | Calibrated time of the hit in picoseconds |

## Verification
The hardest case to reach from the ports is a hit that arrives during a rebuild or just at its edges. It must use the old table and must not count toward the next batch, and the very next hit must see the complete new table. The stimulus keeps hits dense, with a hit in about three cycles out of four, over several batches. This places hits on the batch-completing edge, inside the walk, on its final edge and right after the swap. A bench model follows the batch boundary and tags each check by the phase it falls in. A weighted code mix gives one bin several times the hits of the others. This produces a wide bin and a clearly non-uniform table, which is then swept code by code.

// File: rtl/tdccal_pkg.sv
package tdccal_pkg;

   // phase of the calibration sequencer
   typedef enum logic {
      PH_GATHER = 1'b0,
      PH_WALK   = 1'b1
   } cal_phase_e;

endpackage

// File: rtl/tdccal_hist.sv
// Per-bin hit counters with a single read-and-clear port for the sequencer.
module tdccal_hist #(
   parameter int NBINS = 64,
   parameter int IDX_W = 6,
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc_en,
   input  logic [IDX_W-1:0] inc_idx,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] rd_cnt
);

   logic [CNT_W-1:0] cnt_q [NBINS];

   for (genvar b = 0; b < NBINS; b++) begin : g_bin
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(b);
      always_ff @(posedge clk) begin
         if (rst) begin
            cnt_q[b] <= '0;
         end else if (clr_en && rd_idx == MY_IDX) begin
            cnt_q[b] <= '0;
         end else if (inc_en && inc_idx == MY_IDX) begin
            cnt_q[b] <= cnt_q[b] + 1'b1;
         end
      end
   end

   assign rd_cnt = cnt_q[rd_idx];

endmodule

// File: rtl/tdccal_seq.sv
// Batch counter and table-building walk over the histogram.
module tdccal_seq
   import tdccal_pkg::*;
#(
   parameter int NBINS  = 64,
   parameter int IDX_W  = 6,
   parameter int CNT_W  = 15,
   parameter int BATCH  = 16384,
   parameter int LOG2B  = 14,
   parameter int CLK_PS = 2500,
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hit_valid,
   input  logic [CNT_W-1:0]  bin_cnt,
   output logic              walking,
   output logic [IDX_W-1:0]  walk_idx,
   output logic              tbl_we,
   output logic [TIME_W-1:0] tbl_wdata,
   output logic              tbl_swap
);

   localparam int SUM_W  = CNT_W + 1;
   localparam int NUM_W  = SUM_W + 1;
   localparam int PS_W   = $clog2(CLK_PS + 1);
   localparam int PROD_W = NUM_W + PS_W + TIME_W;
   localparam logic [CNT_W-1:0] LAST_EV  = CNT_W'(BATCH - 1);
   localparam logic [IDX_W-1:0] LAST_BIN = IDX_W'(NBINS - 1);
   localparam logic [PROD_W-1:0] PERIOD  = PROD_W'(CLK_PS);

   cal_phase_e       phase_q;
   logic [CNT_W-1:0] ev_q;
   logic [IDX_W-1:0] idx_q;
   logic [SUM_W-1:0] run_q;

   logic [NUM_W-1:0]  twice_ctr;
   logic [PROD_W-1:0] scaled;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_GATHER;
         ev_q    <= '0;
         idx_q   <= '0;
         run_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_GATHER: begin
               if (hit_valid) begin
                  if (ev_q == LAST_EV) begin
                     ev_q    <= '0;
                     phase_q <= PH_WALK;
                     idx_q   <= '0;
                     run_q   <= '0;
                  end else begin
                     ev_q <= ev_q + 1'b1;
                  end
               end
            end
            PH_WALK: begin
               run_q <= run_q + SUM_W'(bin_cnt);
               idx_q <= idx_q + 1'b1;
               if (idx_q == LAST_BIN) begin
                  phase_q <= PH_GATHER;
               end
            end
            default: phase_q <= PH_GATHER;
         endcase
      end
   end

   // bin centre: running sum below the bin plus half of its own count,
   // kept doubled to stay integer, then scaled by period / (2*BATCH)
   always_comb begin
      twice_ctr = {run_q, 1'b0} + NUM_W'(bin_cnt);
      scaled    = (PROD_W'(twice_ctr) * PERIOD) >> (LOG2B + 1);
   end

   assign walking   = (phase_q == PH_WALK);
   assign walk_idx  = idx_q;
   assign tbl_we    = walking;
   assign tbl_wdata = scaled[TIME_W-1:0];
   assign tbl_swap  = walking && (idx_q == LAST_BIN);

endmodule

// File: rtl/tdccal_lut.sv
// Two-bank bin-to-time table: one bank serves lookups, the other is written.
module tdccal_lut #(
   parameter int NBINS  = 64,
   parameter int IDX_W  = 6,
   parameter int TIME_W = 16,
   parameter int NOM_PS = 39
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TIME_W-1:0] wr_data,
   input  logic              swap,
   output logic              rd_valid,
   output logic [TIME_W-1:0] rd_data,
   output logic              live_bank
);

   logic [TIME_W-1:0] bank_q [2][NBINS];
   logic              sel_q;

   for (genvar bk = 0; bk < 2; bk++) begin : g_bank
      localparam logic MY_BANK = 1'(bk);
      for (genvar e = 0; e < NBINS; e++) begin : g_entry
         localparam logic [IDX_W-1:0]  MY_IDX  = IDX_W'(e);
         localparam logic [TIME_W-1:0] RAMP_PS = TIME_W'(e * NOM_PS);
         always_ff @(posedge clk) begin
            if (rst) begin
               bank_q[bk][e] <= RAMP_PS;
            end else if (wr_en && sel_q != MY_BANK && wr_idx == MY_IDX) begin
               bank_q[bk][e] <= wr_data;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q    <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         if (swap) begin
            sel_q <= ~sel_q;
         end
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_data <= bank_q[sel_q][rd_idx];
         end
      end
   end

   assign live_bank = sel_q;

endmodule

// File: rtl/tdc_bin_calibrator.sv
module tdc_bin_calibrator #(
   parameter int BIN_W  = 6,
   parameter int BATCH  = 16384,
   parameter int CLK_PS = 2500,
   parameter int TIME_W = 16,
   parameter int NOM_PS = CLK_PS / (1 << BIN_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hit_valid,
   input  logic [BIN_W-1:0]  hit_code,
   output logic              cal_valid,
   output logic [TIME_W-1:0] cal_ps
);

   localparam int NBINS = 1 << BIN_W;
   localparam int LOG2B = $clog2(BATCH);
   localparam int CNT_W = $clog2(BATCH + 1);

   if (BIN_W < 1 || BIN_W > 10) begin : g_bad_bin_w
      $error("BIN_W must lie in 1..10");
   end
   if (BATCH < 2 || BATCH != (1 << LOG2B)) begin : g_bad_batch
      $error("BATCH must be a power of two of at least 2");
   end
   if (CLK_PS < 1 || CLK_PS >= (1 << TIME_W)) begin : g_bad_period
      $error("CLK_PS must be positive and fit in TIME_W bits");
   end
   if (NOM_PS * (NBINS - 1) >= (1 << TIME_W)) begin : g_bad_ramp
      $error("default ramp does not fit in TIME_W bits");
   end

   logic              building;
   logic [BIN_W-1:0]  bld_idx;
   logic [CNT_W-1:0]  bin_cnt;
   logic              tbl_we;
   logic [TIME_W-1:0] tbl_wdata;
   logic              tbl_swap;
   logic              bank_sel;

   tdccal_hist #(
      .NBINS (NBINS),
      .IDX_W (BIN_W),
      .CNT_W (CNT_W)
   ) u_hist (
      .clk     (clk),
      .rst     (rst),
      .inc_en  (hit_valid && !building),
      .inc_idx (hit_code),
      .clr_en  (building),
      .rd_idx  (bld_idx),
      .rd_cnt  (bin_cnt)
   );

   tdccal_seq #(
      .NBINS  (NBINS),
      .IDX_W  (BIN_W),
      .CNT_W  (CNT_W),
      .BATCH  (BATCH),
      .LOG2B  (LOG2B),
      .CLK_PS (CLK_PS),
      .TIME_W (TIME_W)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .hit_valid (hit_valid),
      .bin_cnt   (bin_cnt),
      .walking   (building),
      .walk_idx  (bld_idx),
      .tbl_we    (tbl_we),
      .tbl_wdata (tbl_wdata),
      .tbl_swap  (tbl_swap)
   );

   tdccal_lut #(
      .NBINS  (NBINS),
      .IDX_W  (BIN_W),
      .TIME_W (TIME_W),
      .NOM_PS (NOM_PS)
   ) u_lut (
      .clk       (clk),
      .rst       (rst),
      .rd_en     (hit_valid),
      .rd_idx    (hit_code),
      .wr_en     (tbl_we),
      .wr_idx    (bld_idx),
      .wr_data   (tbl_wdata),
      .swap      (tbl_swap),
      .rd_valid  (cal_valid),
      .rd_data   (cal_ps),
      .live_bank (bank_sel)
   );

endmodule

// File: rtl/tdccal_chk.sv
module tdccal_chk #(
   parameter int IDX_W = 6
) (
   input logic             clk,
   input logic             rst,
   input logic             hit_valid,
   input logic             cal_valid,
   input logic             building,
   input logic [IDX_W-1:0] bld_idx,
   input logic             bank_sel
);

   // R2
   hit_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
      hit_valid |=> cal_valid);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !hit_valid |=> !cal_valid);

   // R4
   build_start_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(building) |-> $past(hit_valid));

   // R6
   build_first_bin_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(building) |-> bld_idx == '0);

   // R6
   build_walk_chk: assert property (@(posedge clk) disable iff (rst)
      (building && $past(building)) |-> bld_idx == IDX_W'($past(bld_idx) + 1'b1));

   // R7
   swap_at_end_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(building) |-> bank_sel != $past(bank_sel));

   // R7
   bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$fell(building)) |-> $stable(bank_sel));

endmodule

bind tdc_bin_calibrator tdccal_chk #(
   .IDX_W (BIN_W)
) u_tdccal_chk (
   .clk       (clk),
   .rst       (rst),
   .hit_valid (hit_valid),
   .cal_valid (cal_valid),
   .building  (building),
   .bld_idx   (bld_idx),
   .bank_sel  (bank_sel)
);

// File: tb/tdc_bin_calibrator_bench.sv
module tdc_bin_calibrator_bench;

   localparam int CLK_PERIOD = 10;
   localparam int BIN_W  = 4;
   localparam int NBINS  = 1 << BIN_W;
   localparam int BATCH  = 256;
   localparam int CLK_PS = 2560;
   localparam int TIME_W = 16;
   localparam int NOM_PS = 160;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              hit_valid = 1'b0;
   logic [BIN_W-1:0]  hit_code = '0;
   logic              cal_valid;
   logic [TIME_W-1:0] cal_ps;

   tdc_bin_calibrator #(
      .BIN_W  (BIN_W),
      .BATCH  (BATCH),
      .CLK_PS (CLK_PS),
      .TIME_W (TIME_W),
      .NOM_PS (NOM_PS)
   ) u_tdc_bin_calibrator (
      .clk       (clk),
      .rst       (rst),
      .hit_valid (hit_valid),
      .hit_code  (hit_code),
      .cal_valid (cal_valid),
      .cal_ps    (cal_ps)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // bench model
   int tbl [NBINS];
   int nxt [NBINS];
   int hist [NBINS];
   int ev_n = 0;
   int walk_left = 0;
   int ncal = 0;
   bit fresh = 1'b0;

   bit    pend_v = 1'b0;
   int    pend_exp = 0;
   string pend_tag = "R1";

   function automatic int entry_ps(input int below, input int own);
      return (((2 * below + own) * CLK_PS) / (2 * BATCH)) % (1 << TIME_W);
   endfunction

   function automatic void build_next();
      int run = 0;
      for (int b = 0; b < NBINS; b++) begin
         nxt[b]  = entry_ps(run, hist[b]);
         run    += hist[b];
         hist[b] = 0;
      end
   endfunction

   task automatic check_out();
      checks++;
      if (cal_valid !== pend_v) begin
         errors++;
         $display("FAIL %s: cal_valid=%0b expected %0b", pend_v ? "R2" : "R1",
                  cal_valid, pend_v);
      end
      if (pend_v) begin
         checks++;
         if (cal_ps !== TIME_W'(pend_exp)) begin
            errors++;
            $display("FAIL %s: cal_ps=%0d expected %0d", pend_tag, cal_ps, pend_exp);
         end
      end
   endtask

   task automatic cycle(input bit v, input int c);
      @(negedge clk);
      check_out();
      hit_valid = v;
      hit_code  = BIN_W'(c);
      pend_v    = v;
      pend_exp  = v ? tbl[c] : 0;
      if (walk_left == NBINS)      pend_tag = "R4";
      else if (walk_left > 0)      pend_tag = "R6";
      else if (ncal == 0)          pend_tag = "R3";
      else if (fresh)              pend_tag = "R7";
      else if (ncal >= 2)          pend_tag = "R8";
      else                         pend_tag = "R5";
      if (v && walk_left == 0) fresh = 1'b0;
      // advance model by one edge
      if (walk_left > 0) begin
         walk_left--;
         if (walk_left == 0) begin
            tbl   = nxt;
            ncal++;
            fresh = 1'b1;
         end
      end else if (v) begin
         hist[c]++;
         ev_n++;
         if (ev_n == BATCH) begin
            ev_n      = 0;
            walk_left = NBINS;
            build_next();
         end
      end
   endtask

   initial begin
      for (int b = 0; b < NBINS; b++) begin
         tbl[b]  = b * NOM_PS;
         hist[b] = 0;
      end
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: quiet after reset
      cycle(1'b0, 0);
      cycle(1'b0, 0);
      // R3: uniform ramp before first calibration, both ends of the code range
      for (int c = 0; c < NBINS; c++) cycle(1'b1, c);
      cycle(1'b0, 0);
      cycle(1'b1, NBINS - 1);
      cycle(1'b1, 0);
      // random hits, heavily weighted towards bin 5 (a wide bin), over several batches
      void'($urandom(32'd7741));
      while (ncal < 4) begin
         int r = $urandom % 100;
         int c = (r < 30) ? 5 : ((r < 38) ? 11 : int'($urandom % NBINS));
         cycle(($urandom % 4) != 0, c);
      end
      // R1: idle gap
      repeat (3) cycle(1'b0, 0);
      // R8/R5: sweep the last table code by code
      for (int c = 0; c < NBINS; c++) cycle(1'b1, c);
      cycle(1'b0, 0);
      cycle(1'b0, 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule